// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers eight interrupt request lines and presents one interrupt signal to a processor. A new request is recorded when its line rises. Three 8-bit registers hold the state: the lines that are waiting, the lines that are masked off, and the lines whose handlers are running. A fixed-priority resolver picks the most urgent waiting line that is not masked. It raises the interrupt only when that line outranks every handler already running, so nested service works in the usual way.

The processor answers with two acknowledge pulses. The first pulse moves the chosen line from waiting to running. The second pulse returns an 8-bit vector number, made of a programmed base in the upper five bits and the line number in the lower three. When the handler finishes, the processor writes an end-of-interrupt command to a small register port. That command retires the most urgent running handler. The same port also writes the mask and the vector base.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A low-to-high transition on `irq_in[n]`, seen on a clock edge, marks line n as waiting. The mark stays until line n is taken by a first acknowledge. A line that is already high when reset ends is not seen until it falls and rises again.
- R2: `int_req` is never high because of a line whose mask bit is 1.
- R3: Lower line numbers have higher priority, so line 0 is the most urgent. A waiting line whose mask bit is cleared later is presented at that point.
- R4: An `int_ack` pulse while `int_req` is high takes the winning line. The line leaves the waiting set and enters the running set. `int_req` is low during the cycle that follows, until the second pulse.
- R5: The next `int_ack` pulse after a take makes `vec_valid` high for exactly one cycle. During that cycle `vec_data` equals {base[7:3], line[2:0]}.
- R6: Once `int_req` is high, it stays high until an `int_ack` pulse or a register write.
- R7: `int_req` is raised only when the winning waiting line has a lower number than every running line.
- R8: A write to address 2 (end-of-interrupt) removes the lowest-numbered running line. When no line is running, the write has no effect.
- R9: Reset is synchronous and active high. After reset the mask is 8'hFF, the waiting and running sets are empty, the base is 0, and both `int_req` and `vec_valid` are 0.
- R10: Register port decode. Address 0 writes the mask, where bit n set masks line n. Address 1 writes the base, and only data bits 7:3 are kept. Address 3 has no effect.
- R11: An `int_ack` pulse while `int_req` is low, and no take is outstanding, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 base, 2 end-of-interrupt, 3 unused |
| reg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec_data | output | 8 | Vector number of the serviced line |
| vec_valid | output | 1 | One-cycle strobe marking `vec_data` as valid |

## Verification
The hardest state to reach from the ports is a running handler that blocks or admits a new request. That needs a line held in the running set with no end-of-interrupt sent, followed by a second line that rises. The bench sweeps every ordered pair of lines in that arrangement. It then drains both, which also checks that end-of-interrupt retires the more urgent handler first. A second sweep covers all 255 request patterns under a rotated mask. Each pattern is fully serviced, then unmasked and serviced again, and every vector is checked against a reference model that the bench updates from the requirements.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned NUM_LINES = 8;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);
    localparam int unsigned BASE_W    = VEC_W - LINE_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK = 2'd0,
        REG_BASE = 2'd1,
        REG_EOI  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ACK_IDLE   = 1'b0,
        ACK_VECTOR = 1'b1
    } ack_phase_e;

    typedef struct packed {
        logic                 valid;
        logic [LINE_W-1:0]    idx;
        logic [NUM_LINES-1:0] onehot;
    } pick_t;

    // Lowest-numbered set bit wins (line 0 is most urgent).
    function automatic pick_t pick_lowest(input logic [NUM_LINES-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid     = 1'b1;
                p.idx       = LINE_W'(i);
                p.onehot    = '0;
                p.onehot[i] = 1'b1;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irq_edge_pending.sv
module irq_edge_pending
    import irq_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] rise;

    assign rise = irq_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '1;
            pending <= '0;
        end else begin
            prev_q  <= irq_in;
            pending <= (pending & ~clr) | rise;
        end
    end

    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~clr) != '0) |=>
            ((pending & $past(pending & ~clr)) == $past(pending & ~clr)));

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_ctrl_pkg::*;
(
    input  logic [NUM_LINES-1:0] pending,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] isr,
    input  ack_phase_e           phase,
    output pick_t                winner,
    output logic                 raise
);

    logic [NUM_LINES-1:0] cand;
    pick_t                top_srv;
    logic                 outranks;

    always_comb begin
        cand     = pending & ~mask;
        winner   = pick_lowest(cand);
        top_srv  = pick_lowest(isr);
        outranks = !top_srv.valid || (winner.idx < top_srv.idx);
        raise    = winner.valid && outranks && (phase == ACK_IDLE);
    end

endmodule

// File: rtl/irq_service_ctl.sv
module irq_service_ctl
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               int_ack,
    input  logic               raise,
    input  pick_t              winner,
    input  logic               eoi,
    input  logic [BASE_W-1:0]  base,
    output logic [NUM_LINES-1:0] take_clr,
    output logic [NUM_LINES-1:0] isr,
    output ack_phase_e         phase,
    output logic [VEC_W-1:0]   vec_data,
    output logic               vec_valid
);

    logic                 take;
    logic [LINE_W-1:0]    line_q;
    logic [NUM_LINES-1:0] eoi_clr;
    pick_t                srv_top;

    always_comb begin
        take     = int_ack && raise;
        take_clr = take ? winner.onehot : '0;
        srv_top  = pick_lowest(isr);
        eoi_clr  = eoi ? srv_top.onehot : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            phase     <= ACK_IDLE;
            line_q    <= '0;
            vec_data  <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            isr       <= (isr & ~eoi_clr) | take_clr;
            case (phase)
                ACK_IDLE: begin
                    if (take) begin
                        phase  <= ACK_VECTOR;
                        line_q <= winner.idx;
                    end
                end
                ACK_VECTOR: begin
                    if (int_ack) begin
                        vec_data  <= {base, line_q};
                        vec_valid <= 1'b1;
                        phase     <= ACK_IDLE;
                    end
                end
                default: phase <= ACK_IDLE;
            endcase
        end
    end

    // R4
    ack_moves_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ((isr & $past(winner.onehot)) != '0));

    // R5
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(phase == ACK_VECTOR && int_ack));

    // R8
    eoi_one_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !take && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

    // R8
    eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !take && isr == '0) |=> (isr == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [VEC_W-1:0]     reg_wdata,
    input  logic                 int_ack,
    output logic                 int_req,
    output logic [VEC_W-1:0]     vec_data,
    output logic                 vec_valid
);

    logic [NUM_LINES-1:0] mask_q;
    logic [BASE_W-1:0]    base_q;
    logic [NUM_LINES-1:0] pending;
    logic [NUM_LINES-1:0] isr;
    logic [NUM_LINES-1:0] take_clr;
    pick_t                winner;
    ack_phase_e           phase;
    logic                 raise;
    logic                 eoi;
    reg_sel_e             sel;

    assign sel = reg_sel_e'(reg_addr);
    assign eoi = reg_wr && (sel == REG_EOI);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            base_q <= '0;
        end else if (reg_wr) begin
            case (sel)
                REG_MASK: mask_q <= reg_wdata[NUM_LINES-1:0];
                REG_BASE: base_q <= reg_wdata[VEC_W-1:LINE_W];
                default:  ;
            endcase
        end
    end

    irq_edge_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .clr     (take_clr),
        .pending (pending)
    );

    irq_prio_resolve u_res (
        .pending (pending),
        .mask    (mask_q),
        .isr     (isr),
        .phase   (phase),
        .winner  (winner),
        .raise   (raise)
    );

    irq_service_ctl u_srv (
        .clk       (clk),
        .rst       (rst),
        .int_ack   (int_ack),
        .raise     (raise),
        .winner    (winner),
        .eoi       (eoi),
        .base      (base_q),
        .take_clr  (take_clr),
        .isr       (isr),
        .phase     (phase),
        .vec_data  (vec_data),
        .vec_valid (vec_valid)
    );

    assign int_req = raise;

    // R2
    masked_no_int_chk: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((pending & ~mask_q) != '0));

    // R6
    int_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ack && !reg_wr) |=> int_req);

    // R7
    nest_block_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && isr != '0) |-> ((pending & ~mask_q & (isr - 8'd1) & ~isr) != '0));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       int_ack;
    logic       int_req;
    logic [7:0] vec_data;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench reference state
    logic [7:0] m_pend, m_mask, m_isr;
    logic [4:0] m_base;
    bit         m_phase;

    always #4 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_ack(int_ack),
        .int_req(int_req), .vec_data(vec_data), .vec_valid(vec_valid)
    );

    function automatic int lowest(input logic [7:0] v);
        int r = 8;
        for (int i = 7; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic exp_int();
        logic [7:0] cand = m_pend & ~m_mask;
        if (m_phase || cand == 8'h00) return 1'b0;
        return lowest(cand) < lowest(m_isr);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_irq(input logic [7:0] bits);
        irq_in = bits;
        tick();
        irq_in = 8'h00;
        m_pend = m_pend | bits;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        if (a == 2'd0) m_mask = d;
        if (a == 2'd1) m_base = d[7:3];
        if (a == 2'd2 && m_isr != 8'h00) m_isr[lowest(m_isr)] = 1'b0;
    endtask

    // one acknowledge pulse; returns at the negedge after the edge
    task automatic ack();
        logic take;
        take = exp_int();
        int_ack = 1'b1;
        tick();
        int_ack = 1'b0;
        if (m_phase) m_phase = 1'b0;
        else if (take) begin
            int w = lowest(m_pend & ~m_mask);
            m_isr[w] = 1'b1;
            m_pend[w] = 1'b0;
            m_phase = 1'b1;
        end
    endtask

    task automatic serve_one(input bit do_eoi);
        int w = lowest(m_pend & ~m_mask);
        ack();
        chk("R4 int_req low after take", int_req, exp_int());
        ack();
        chk("R5 vec_valid", vec_valid, 1'b1);
        chk("R5 vec_data", vec_data, {m_base, 3'(w)});
        if (do_eoi) begin
            wr(2'd2, 8'h00);
            chk("R8 int_req after eoi", int_req, exp_int());
        end
    endtask

    initial begin
        rst = 1'b1; irq_in = 8'h0F; reg_wr = 1'b0; reg_addr = 2'd0;
        reg_wdata = 8'h00; int_ack = 1'b0;
        m_pend = 8'h00; m_mask = 8'hFF; m_isr = 8'h00; m_base = 5'd0; m_phase = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 int_req at reset", int_req, 1'b0);
        chk("R9 vec_valid at reset", vec_valid, 1'b0);
        tick();
        wr(2'd0, 8'h00);
        chk("R1 line high across reset not seen", int_req, 1'b0);
        irq_in = 8'h00;
        tick();
        pulse_irq(8'h02);
        chk("R1 rise marks waiting", int_req, 1'b1);
        serve_one(1'b1);
        chk("R9 base zero vector", vec_data, 8'h01);

        // R11: ack with nothing waiting is ignored
        ack();
        chk("R11 no vector on stray ack", vec_valid, 1'b0);
        pulse_irq(8'h08);
        chk("R11 request raised", int_req, 1'b1);
        serve_one(1'b1);

        // R10/R3: address 3 is inert; unmasking presents waiting line
        wr(2'd0, 8'hFF);
        pulse_irq(8'h04);
        chk("R2 masked line silent", int_req, 1'b0);
        wr(2'd3, 8'h00);
        chk("R10 addr 3 no effect", int_req, 1'b0);
        wr(2'd1, 8'hA7);
        wr(2'd0, 8'h00);
        chk("R3 unmask presents waiting", int_req, 1'b1);
        serve_one(1'b1);
        chk("R10 base keeps bits 7:3", vec_data, 8'hA2);

        // R8: eoi with nothing running
        wr(2'd2, 8'h00);
        chk("R8 empty eoi no effect", int_req, 1'b0);

        // R6: request held over idle cycles
        pulse_irq(8'h40);
        repeat (5) tick();
        chk("R6 int_req held", int_req, 1'b1);
        serve_one(1'b1);

        // sweep all patterns under rotated masks
        for (int pat = 1; pat < 256; pat++) begin
            wr(2'd1, {pat[4:0], 3'b101});
            wr(2'd0, {pat[3:0], pat[7:4]});
            pulse_irq(8'(pat));
            chk("R2 R3 int_req after pattern", int_req, exp_int());
            for (int k = 0; k < 8; k++) if (exp_int()) serve_one(1'b1);
            chk("R2 masked lines stay silent", int_req, 1'b0);
            wr(2'd0, 8'h00);
            chk("R3 unmasked waiting presented", int_req, exp_int());
            for (int k = 0; k < 8; k++) if (exp_int()) serve_one(1'b1);
            chk("R1 all serviced", int_req, 1'b0);
        end

        // nesting sweep: line j running, line i rises
        wr(2'd0, 8'h00);
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < 8; i++) begin
                pulse_irq(8'(1 << j));
                serve_one(1'b0);
                pulse_irq(8'(1 << i));
                chk("R7 nesting", int_req, (i < j) ? 1'b1 : 1'b0);
                for (int k = 0; k < 6; k++) begin
                    if (exp_int()) serve_one(1'b1);
                    else if (m_isr != 8'h00) begin
                        wr(2'd2, 8'h00);
                        chk("R8 eoi drains most urgent", int_req, exp_int());
                    end
                end
                chk("R8 drained", int_req, 1'b0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule